// File: doc/BRIEF.md
# Wavefront Switch Allocator

This block pairs N requesters with N resources in one combinational pass. Each cycle it takes a square request matrix and returns a grant matrix in which no requester and no resource holds more than one grant. A row token for every requester and a column token for every resource are all released at once on one wrapped anti-diagonal of an N by N cell array. A token moves across its row (or down its column) one diagonal at a time. A cell that wants its resource and sees both tokens keeps them and wins. Every other cell passes the tokens on to the next diagonal.

The diagonal where the tokens start is kept in a small register. It moves forward by one, wrapping at N, after every cycle in which at least one grant was given. This rotates first claim on the matrix among the cells over time. A typical use is the switch allocation stage of a router. The requests there are the (input port, output port) pairs that want the crossbar, and the grants become the crossbar select lines in the same cycle.

Top module: `wavefront_alloc`

## Requirements
- R1: Reset sets the start-diagonal index `prio_o` to 0. With no requests, every bit of `gnt_o` is 0.
- R2: Bit i*N+j of `req_i` means requester i wants resource j. `gnt_o` uses the same bit layout. A grant bit is set only where the matching request bit is set.
- R3: Each requester (row i, bits i*N to i*N+N-1) holds at most one grant.
- R4: Each resource (column j, bits j, N+j, 2N+j, ...) holds at most one grant.
- R5: A cell (i,j) with (i+j) mod N equal to `prio_o` is always granted when it requests.
- R6: Every request that goes ungranted has a grant elsewhere in its own row or in its own column.
- R7: The grant matrix equals a diagonal sweep from `prio_o`. The sweep visits diagonals d = prio_o, prio_o+1, ... (mod N), where diagonal d holds the cells with (i+j) mod N = d. On each diagonal it grants every requesting cell whose row and column are both still unclaimed. For N=4, start 0 and requests {0,1,2}, {0,1}, {0}, {0,2} from requesters 0 to 3, the grants are (0,0), (3,2) and (1,1).
- R8: After a clock edge at which any grant was given, `prio_o` has advanced by one, with N-1 wrapping to 0. After an edge with no grant, it is unchanged.
- R9: Grants depend only on the present `req_i` and `prio_o`. They appear in the same cycle as the requests, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | N*N | Request matrix, bit i*N+j = requester i wants resource j |
| gnt_o | output | N*N | Grant matrix, same layout as req_i |
| prio_o | output | max(1,clog2(N)) | Current start diagonal |

## Verification
The bench goes through every 16-bit request matrix for N=4 in turn. The start diagonal therefore keeps rotating, and every pattern is seen under whatever start index is current at that point. Two kinds of error are aimed at. A token chain that wraps at the wrong row or column would grant two cells in one column, or would miss a free pair and break maximality. A wrong diagonal offset between the rotated view and the real matrix would award the wrong cell on the start diagonal, and the full-matrix comparison shows that. Empty-request cycles check that the start index holds when nothing is granted, and cycles full of requests check the wrap from N-1 to 0.

// File: rtl/wfa_pkg.sv
package wfa_pkg;

    // non-negative modulo used for diagonal arithmetic
    function automatic int wrap_mod(input int a, input int n);
        return ((a % n) + n) % n;
    endfunction

endpackage

// File: rtl/wfa_rotate.sv
// Re-indexes the request/grant matrix between real columns and
// diagonal distance from the start diagonal. Row stays the same.
module wfa_rotate #(
    parameter int N       = 4,
    parameter int PW      = 2,
    parameter bit INVERSE = 1'b0
) (
    input  logic [PW-1:0]  base_i,
    input  logic [N*N-1:0] src_i,
    output logic [N*N-1:0] dst_o
);
    import wfa_pkg::*;

    generate
        if (INVERSE) begin : g_to_cols
            // dst column c takes src distance (i + c - base) mod N
            always_comb begin
                for (int i = 0; i < N; i++) begin
                    for (int c = 0; c < N; c++) begin
                        dst_o[i*N + c] = src_i[i*N + wrap_mod(i + c - int'(base_i), N)];
                    end
                end
            end
        end else begin : g_to_diag
            // dst distance d takes src column (d - i + base) mod N
            always_comb begin
                for (int i = 0; i < N; i++) begin
                    for (int d = 0; d < N; d++) begin
                        dst_o[i*N + d] = src_i[i*N + wrap_mod(d - i + int'(base_i), N)];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wfa_core.sv
// Token array in rotated coordinates: cell (i,d) is requester i at
// diagonal distance d. Row token comes from (i,d-1), column token
// from (i-1 mod N, d-1); distance 0 receives fresh tokens.
module wfa_core #(
    parameter int N = 4
) (
    input  logic [N*N-1:0] rreq_i,
    output logic [N*N-1:0] rgnt_o
);
    logic row_tok [N][N];
    logic col_tok [N][N];
    logic win     [N][N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_row
            for (genvar d = 0; d < N; d++) begin : g_dist
                localparam int UP = (i + N - 1) % N;
                if (d == 0) begin : g_inject
                    assign row_tok[i][d] = 1'b1;
                    assign col_tok[i][d] = 1'b1;
                end else begin : g_pass
                    assign row_tok[i][d] = row_tok[i][d-1]  & ~win[i][d-1];
                    assign col_tok[i][d] = col_tok[UP][d-1] & ~win[UP][d-1];
                end
                assign win[i][d]      = rreq_i[i*N + d] & row_tok[i][d] & col_tok[i][d];
                assign rgnt_o[i*N + d] = win[i][d];
            end
        end
    endgenerate

endmodule

// File: rtl/wfa_prio.sv
// Start-diagonal register, advanced once per cycle with a grant.
module wfa_prio #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_gnt_i,
    output logic [PW-1:0] ptr_o
);
    typedef struct packed {
        logic [PW-1:0] ptr;
    } prio_state_t;

    prio_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (any_gnt_i) begin
            if (st_q.ptr == PW'(N - 1)) st_d.ptr = '0;
            else                         st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;

    // R8
    prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_gnt_i |=> $stable(ptr_o));

    // R8
    prio_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_gnt_i |=> (ptr_o == (($past(ptr_o) == PW'(N - 1)) ? '0 : $past(ptr_o) + 1'b1)));

endmodule

// File: rtl/wavefront_alloc.sv
module wavefront_alloc #(
    parameter int N = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N*N-1:0]                  req_i,
    output logic [N*N-1:0]                  gnt_o,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] prio_o
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [N*N-1:0] rot_req;
    logic [N*N-1:0] rot_gnt;
    logic           any_gnt;

    wfa_rotate #(.N(N), .PW(PW), .INVERSE(1'b0)) u_fwd (
        .base_i (prio_o),
        .src_i  (req_i),
        .dst_o  (rot_req)
    );

    wfa_core #(.N(N)) u_core (
        .rreq_i (rot_req),
        .rgnt_o (rot_gnt)
    );

    wfa_rotate #(.N(N), .PW(PW), .INVERSE(1'b1)) u_inv (
        .base_i (prio_o),
        .src_i  (rot_gnt),
        .dst_o  (gnt_o)
    );

    assign any_gnt = |gnt_o;

    wfa_prio #(.N(N), .PW(PW)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_gnt_i (any_gnt),
        .ptr_o     (prio_o)
    );

    // ---------------- checks on the grant matrix ----------------
    logic [N-1:0] row_any;
    logic [N-1:0] col_any;

    always_comb begin
        for (int r = 0; r < N; r++) begin
            row_any[r] = |gnt_o[r*N +: N];
        end
        for (int c = 0; c < N; c++) begin
            col_any[c] = 1'b0;
            for (int r = 0; r < N; r++) col_any[c] = col_any[c] | gnt_o[r*N + c];
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk_row
            // R3
            row_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(gnt_o[i*N +: N]));
        end
        for (genvar j = 0; j < N; j++) begin : g_chk_col
            logic [N-1:0] colv;
            always_comb begin
                for (int r = 0; r < N; r++) colv[r] = gnt_o[r*N + j];
            end
            // R4
            col_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(colv));
        end
        for (genvar i = 0; i < N; i++) begin : g_chk_cell_r
            for (genvar j = 0; j < N; j++) begin : g_chk_cell_c
                localparam int K = (i + j) % N;
                // R2
                gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    gnt_o[i*N + j] |-> req_i[i*N + j]);
                // R5
                start_diag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (req_i[i*N + j] && (prio_o == PW'(K))) |-> gnt_o[i*N + j]);
                // R6
                maximal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (req_i[i*N + j] && !gnt_o[i*N + j]) |-> (row_any[i] || col_any[j]));
            end
        end
    endgenerate

endmodule

// File: tb/wavefront_alloc_tb_top.sv
`timescale 1ns/1ps
module wavefront_alloc_tb_top;
    localparam int N  = 4;
    localparam int NN = N * N;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NN-1:0] req_i = '0;
    logic [NN-1:0] gnt_o;
    logic [PW-1:0] prio_o;

    int checks = 0;
    int bad    = 0;
    bit done   = 1'b0;
    int exp_p  = 0;

    always #10 clk = ~clk;   // 50 MHz

    wavefront_alloc #(.N(N)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .gnt_o  (gnt_o),
        .prio_o (prio_o)
    );

    // sequential diagonal sweep with claimed-row/column flags
    function automatic logic [NN-1:0] model(input logic [NN-1:0] r, input int p);
        logic [N-1:0] row_taken;
        logic [N-1:0] col_taken;
        logic [NN-1:0] g;
        row_taken = '0; col_taken = '0; g = '0;
        for (int s = 0; s < N; s++) begin
            int k;
            k = (p + s) % N;
            for (int i = 0; i < N; i++) begin
                int j;
                j = (k - i + N) % N;
                if (r[i*N + j] && !row_taken[i] && !col_taken[j]) begin
                    g[i*N + j] = 1'b1;
                    row_taken[i] = 1'b1;
                    col_taken[j] = 1'b1;
                end
            end
        end
        return g;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h req=%h", req, act, exp, req_i);
        end
    endtask

    // all property-style checks on the current output, then exact match
    task automatic check_pattern();
        logic [NN-1:0] e;
        bit ok_r2, ok_r3, ok_r4, ok_r5, ok_r6;
        e = model(req_i, exp_p);
        ok_r2 = ((gnt_o & ~req_i) == '0);
        ok_r3 = 1'b1; ok_r4 = 1'b1; ok_r5 = 1'b1; ok_r6 = 1'b1;
        for (int i = 0; i < N; i++) begin
            int rc, cc;
            rc = 0; cc = 0;
            for (int j = 0; j < N; j++) begin
                rc += int'(gnt_o[i*N + j]);
                cc += int'(gnt_o[j*N + i]);
            end
            if (rc > 1) ok_r3 = 1'b0;
            if (cc > 1) ok_r4 = 1'b0;
        end
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (req_i[i*N + j] && ((i + j) % N == exp_p) && !gnt_o[i*N + j]) ok_r5 = 1'b0;
                if (req_i[i*N + j] && !gnt_o[i*N + j]) begin
                    bit seen;
                    seen = 1'b0;
                    for (int m = 0; m < N; m++) begin
                        if (gnt_o[i*N + m] || gnt_o[m*N + j]) seen = 1'b1;
                    end
                    if (!seen) ok_r6 = 1'b0;
                end
            end
        end
        check(prio_o == PW'(exp_p), "R8 start index", 32'(prio_o), 32'(exp_p));
        check(ok_r2, "R2 grant without request", 32'(gnt_o), 32'(e));
        check(ok_r3, "R3 row holds two grants", 32'(gnt_o), 32'(e));
        check(ok_r4, "R4 column holds two grants", 32'(gnt_o), 32'(e));
        check(ok_r5, "R5 start diagonal request lost", 32'(gnt_o), 32'(e));
        check(ok_r6, "R6 matching not maximal", 32'(gnt_o), 32'(e));
        check(gnt_o == e, "R7 R9 grant matrix", 32'(gnt_o), 32'(e));
    endtask

    task automatic apply(input logic [NN-1:0] v);
        @(negedge clk);
        req_i = v;
        #5;
        check_pattern();
        if (gnt_o != '0) exp_p = (exp_p + 1) % N;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #5;
        // R1
        check(prio_o == '0, "R1 reset start index", 32'(prio_o), 32'd0);
        check(gnt_o == '0, "R1 idle grants", 32'(gnt_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #5;
        check(prio_o == '0, "R1 index after release", 32'(prio_o), 32'd0);

        // R7 worked example at start 0: grants (0,0), (1,1), (3,2)
        @(negedge clk);
        req_i = 16'h5137;
        #5;
        check(gnt_o == 16'h4021, "R7 worked example", 32'(gnt_o), 32'h4021);
        check_pattern();
        exp_p = 1;

        // R8 hold with no requests
        for (int h = 0; h < 3; h++) apply('0);

        // R8 wrap through several full matrices
        for (int h = 0; h < 6; h++) apply('1);

        // exhaustive sweep of all request matrices
        for (int v = 0; v < (1 << NN); v++) apply(NN'(v));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL R7 watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule